// File: doc/BRIEF.md
# Stereo Audio Capture Burst Packer

This block sits between a serial digital audio receiver and a memory write port. Each cycle the receiver may present one decoded stereo frame, which is a left and a right sample. The block turns the frame into one or two 32-bit memory words according to a sample-width mode, and can reverse the bytes of each word for big-endian storage. Words are gathered into 16-word (64-byte) bursts in an internal buffer that holds two bursts, so one burst can drain while the next one fills.

The receiver cannot be stalled, so the frame input has no ready signal. When the buffer lacks room for a whole frame, that frame is discarded and a sticky bandwidth-error flag is raised. Software clears the flag with a write-one-to-clear pulse. The memory side takes words through a valid/ready stream. `wr_valid` rises only once a complete burst is stored. While `wr_ready` is low, the offered word and its last-marker stay unchanged. Clearing `cap_en` stops sampling and fills any partly built burst with zero words so that it can leave the block.

Top module: `audio_burst_packer`

## Requirements
- R1: With `fmt_sel` = 2'b00 (16-bit stereo), each accepted frame yields one word: bits 15:0 hold `in_left[15:0]` and bits 31:16 hold `in_right[15:0]`.
- R2: With `fmt_sel` = 2'b01 (32-bit stereo), each accepted frame yields two words: `in_left` first, then `in_right`.
- R3: With `fmt_sel` = 2'b10 or 2'b11 (raw), each accepted frame yields one word equal to `in_left`, and `in_right` is ignored.
- R4: With `big_endian` = 1, the bytes of every packed word are reversed: bits 7:0 swap with bits 31:24, and bits 15:8 swap with bits 23:16.
- R5: Words leave in bursts of 16 in arrival order. `wr_last` is high on every 16th transferred word. `wr_valid` is never high unless at least one complete burst is stored.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_last` hold their values into the next cycle.
- R7: The buffer holds 32 words. A frame is accepted only when the free space is at least the number of words it yields, measured before that cycle's transfer. Otherwise the whole frame is dropped and `bw_err` is 1 from the next cycle.
- R8: `bw_err` stays 1 until `bw_err_clr` is pulsed. A drop in the same cycle as the clear leaves it at 1.
- R9: While `cap_en` is 0, frames are ignored. If a burst is partly filled, one zero word per cycle is added while space allows, until the burst is complete.
- R10: After reset, `wr_valid` is 0, `bw_err` is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable; low flushes a partial burst |
| fmt_sel | input | 2 | 00 16-bit stereo, 01 32-bit stereo, 1x raw |
| big_endian | input | 1 | Reverse bytes within each word |
| bw_err_clr | input | 1 | Write-one-to-clear pulse for `bw_err` |
| in_valid | input | 1 | Frame present this cycle |
| in_left | input | 32 | Left sample (raw word in raw mode) |
| in_right | input | 32 | Right sample |
| wr_valid | output | 1 | Memory word offered |
| wr_ready | input | 1 | Memory side takes the word |
| wr_data | output | 32 | Memory word |
| wr_last | output | 1 | Final word of a 16-word burst |
| bw_err | output | 1 | Sticky bandwidth-error flag |

## Verification
A wrong fill or read count shows up as `wr_last` landing on the wrong beat, or as zero padding of the wrong length. Either appears within one burst of the fault. A wrong buffer level either drops frames that should have fit, with `bw_err` rising one cycle after the frame, or keeps frames that should have been dropped. The latter appears as extra or reordered words on the very next drained burst. Packing or byte-order faults corrupt the first word that the affected frame produces.

// File: rtl/apk_pkg.sv
package apk_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_S16  = 2'b00,
    FMT_S32  = 2'b01,
    FMT_RAW  = 2'b10,
    FMT_RAWB = 2'b11
  } fmt_e;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++) begin
      r[b*8 +: 8] = w[(WORD_W/8-1-b)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/apk_frame_packer.sv
module apk_frame_packer
  import apk_pkg::*;
(
  input  logic [1:0]        fmt_sel,
  input  logic              big_endian,
  input  logic [WORD_W-1:0] left,
  input  logic [WORD_W-1:0] right,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1,
  output logic [1:0]        nwords
);
  logic [WORD_W-1:0] p0, p1;

  always_comb begin
    p1 = '0;
    unique case (fmt_e'(fmt_sel))
      FMT_S16: begin
        p0     = {right[WORD_W/2-1:0], left[WORD_W/2-1:0]};
        nwords = 2'd1;
      end
      FMT_S32: begin
        p0     = left;
        p1     = right;
        nwords = 2'd2;
      end
      default: begin
        p0     = left;
        nwords = 2'd1;
      end
    endcase
    word0 = big_endian ? byte_rev(p0) : p0;
    word1 = big_endian ? byte_rev(p1) : p1;
  end
endmodule

// File: rtl/apk_word_fifo.sv
module apk_word_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n,
  input  logic [W-1:0]  din0,
  input  logic [W-1:0]  din1,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   level
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= din0;
    if (push_n == 2'd2) mem[wp + ONE] <= din1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      if (pop) rp <= rp + ONE;
      level <= level + (AW+1)'(push_n) - (AW+1)'(pop);
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/apk_burst_ctrl.sv
module apk_burst_ctrl #(
  parameter int DEPTH = 32,
  parameter int BURST = 16,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int BW   = $clog2(BURST),
  localparam int NB   = DEPTH / BURST,
  localparam int CW   = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          in_valid,
  input  logic [1:0]    need,
  input  logic [LW-1:0] level,
  input  logic          wr_ready,
  input  logic          bw_err_clr,
  output logic [1:0]    push_n,
  output logic          pad,
  output logic          pop,
  output logic          wr_valid,
  output logic          wr_last,
  output logic          bw_err
);
  logic [BW-1:0] fill_cnt, rd_cnt;
  logic [CW-1:0] bursts;
  logic [LW-1:0] free;
  logic [BW:0]   sum;
  logic          accept, drop, burst_done, pop_last;

  always_comb begin
    free       = LW'(DEPTH) - level;
    accept     = cap_en && in_valid && (free >= LW'(need));
    drop       = cap_en && in_valid && (free <  LW'(need));
    pad        = !cap_en && (fill_cnt != '0) && (free != '0);
    push_n     = accept ? need : (pad ? 2'd1 : 2'd0);
    sum        = {1'b0, fill_cnt} + (BW+1)'(push_n);
    burst_done = sum >= (BW+1)'(BURST);
    wr_valid   = bursts != '0;
    wr_last    = rd_cnt == BW'(BURST - 1);
    pop        = wr_valid && wr_ready;
    pop_last   = pop && wr_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      rd_cnt   <= '0;
      bursts   <= '0;
      bw_err   <= 1'b0;
    end else begin
      fill_cnt <= sum[BW-1:0];
      if (pop) rd_cnt <= rd_cnt + BW'(1);
      bursts   <= bursts + CW'(burst_done) - CW'(pop_last);
      if (drop)            bw_err <= 1'b1;
      else if (bw_err_clr) bw_err <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_burst_packer.sv
module audio_burst_packer
  import apk_pkg::*;
#(
  parameter int BURST_WORDS = 16,
  parameter int BUF_BURSTS  = 2,
  localparam int DEPTH      = BURST_WORDS * BUF_BURSTS,
  localparam int LW         = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        fmt_sel,
  input  logic              big_endian,
  input  logic              bw_err_clr,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_last,
  output logic              bw_err
);
  logic [WORD_W-1:0] w0, w1, din0, din1;
  logic [1:0]        need, push_n;
  logic [LW-1:0]     fifo_level;
  logic              pad, pop;

  apk_frame_packer u_pack (
    .fmt_sel(fmt_sel), .big_endian(big_endian), .left(in_left), .right(in_right),
    .word0(w0), .word1(w1), .nwords(need)
  );

  assign din0 = pad ? '0 : w0;
  assign din1 = w1;

  apk_burst_ctrl #(.DEPTH(DEPTH), .BURST(BURST_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .in_valid(in_valid), .need(need),
    .level(fifo_level), .wr_ready(wr_ready), .bw_err_clr(bw_err_clr),
    .push_n(push_n), .pad(pad), .pop(pop), .wr_valid(wr_valid),
    .wr_last(wr_last), .bw_err(bw_err)
  );

  apk_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .din0(din0), .din1(din1),
    .pop(pop), .dout(wr_data), .level(fifo_level)
  );
endmodule

// File: rtl/apk_checker.sv
module apk_checker #(
  parameter int DEPTH = 32,
  parameter int BURST = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          in_valid,
  input logic [1:0]    fmt_sel,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [31:0]   wr_data,
  input logic          wr_last,
  input logic          bw_err,
  input logic          bw_err_clr,
  input logic [LW-1:0] level
);
  int beat;
  int need_w;

  assign need_w = (fmt_sel == 2'b01) ? 2 : 1;

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= 0;
    else if (wr_valid && wr_ready) beat <= (beat == BURST - 1) ? 0 : beat + 1;
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_last)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R7
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && in_valid && (int'(level) + need_w > DEPTH) |=> bw_err); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bw_err && !bw_err_clr |=> bw_err); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bw_err && bw_err_clr && !in_valid |=> !bw_err); // R8
  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |-> wr_last == (beat == BURST - 1)); // R5
  AST_VALID_NEEDS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> level != '0); // R5
endmodule

bind audio_burst_packer apk_checker #(.DEPTH(DEPTH), .BURST(BURST_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .in_valid(in_valid), .fmt_sel(fmt_sel),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
  .bw_err(bw_err), .bw_err_clr(bw_err_clr), .level(fifo_level)
);

// File: tb/audio_burst_packer_tb.sv
module audio_burst_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int BURST = 16;

  logic clk = 0, rst_n = 0, cap_en = 0, big_endian = 0, bw_err_clr = 0, in_valid = 0;
  logic [1:0] fmt_sel = 0;
  logic [31:0] in_left = 0, in_right = 0;
  logic wr_valid, wr_ready = 0, wr_last, bw_err;
  logic [31:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_burst_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fmt_sel(fmt_sel), .big_endian(big_endian),
    .bw_err_clr(bw_err_clr), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .bw_err(bw_err)
  );

  int checks = 0, fails = 0, cyc = 0, beat = 0, rdy_mode = 0;
  int m_level = 0, m_fill = 0;
  bit m_err = 0, done = 0;
  bit en = 0, be = 0;
  logic [1:0] fmt = 0;
  logic [31:0] q_data[$];
  string q_tag[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rev(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic enq(logic [31:0] w, string tag);
    q_data.push_back(be ? rev(w) : w);
    q_tag.push_back(be ? {tag, "/R4"} : tag);
  endtask

  task automatic step(bit v, logic [31:0] l, logic [31:0] r, bit clr);
    int need, free, push, popn;
    bit drop;
    @(negedge clk);
    cyc++;
    wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ((cyc % 3) != 0);
    chk(bw_err == m_err, "R8 bw_err", 32'(bw_err), 32'(m_err));
    popn = 0;
    if (wr_valid && wr_ready) begin
      if (q_data.size() == 0) begin
        chk(0, "R5 unexpected word", wr_data, 0);
      end else begin
        string t;
        logic [31:0] e;
        e = q_data.pop_front();
        t = q_tag.pop_front();
        chk(wr_data == e, t, wr_data, e);
      end
      chk(wr_last == ((beat % BURST) == BURST - 1), "R5 wr_last", 32'(wr_last),
          32'((beat % BURST) == BURST - 1));
      beat++;
      popn = 1;
    end
    cap_en = en; fmt_sel = fmt; big_endian = be;
    in_valid = v; in_left = l; in_right = r; bw_err_clr = clr;
    need = (fmt == 2'b01) ? 2 : 1;
    free = DEPTH - m_level;
    push = 0; drop = 0;
    if (en && v) begin
      if (free >= need) begin
        push = need;
        case (fmt)
          2'b00: enq({r[15:0], l[15:0]}, "R1");
          2'b01: begin enq(l, "R2"); enq(r, "R2"); end
          default: enq(l, "R3");
        endcase
      end else drop = 1;
    end else if (!en && m_fill != 0 && free > 0) begin
      push = 1;
      q_data.push_back(32'h0);
      q_tag.push_back("R9 pad");
    end
    m_fill = (m_fill + push) % BURST;
    m_level = m_level + push - popn;
    m_err = drop ? 1'b1 : (clr ? 1'b0 : m_err);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_valid == 0, "R10 wr_valid", 32'(wr_valid), 0);
    chk(bw_err == 0, "R10 bw_err", 32'(bw_err), 0);

    // Sweep every mode and byte order, with two ready patterns.
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        fmt = 2'(m); be = b[0]; en = 1;
        rdy_mode = (m + b) % 2;
        step(0, 0, 0, 1);
        for (int k = 0; k < 24; k++) begin
          step(1, {8'(k), 8'(m * 16 + b), 8'(k * 7), 8'hA5},
                  {8'hC3, 8'(k * 5), 8'(m), 8'(~k)}, 0);
          if (k % 3 == 2) step(0, 0, 0, 0);
        end
        en = 0;
        rdy_mode = 0;
        for (int i = 0; i < 45; i++) step(0, 0, 0, 0);
      end
    end

    // Overflow: memory side stalled, 32-bit frames.
    fmt = 2'b01; be = 0; en = 1; rdy_mode = 2;
    step(0, 0, 0, 1);
    for (int k = 0; k < 20; k++) step(1, 32'h1000_0000 + k, 32'h2000_0000 + k, 0);
    step(0, 0, 0, 0);
    chk(bw_err == 1, "R7 drop sets bw_err", 32'(bw_err), 1);
    begin
      logic [31:0] hd;
      hd = wr_data;
      chk(wr_valid == 1, "R6 valid offered", 32'(wr_valid), 1);
      step(0, 0, 0, 0);
      chk(wr_valid == 1 && wr_data == hd, "R6 hold under stall", wr_data, hd);
    end
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk(bw_err == 0, "R8 cleared", 32'(bw_err), 0);
    step(1, 32'hDEAD_0001, 32'hDEAD_0002, 1);
    step(0, 0, 0, 0);
    chk(bw_err == 1, "R8 drop beats clear", 32'(bw_err), 1);
    rdy_mode = 0; en = 0;
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0);

    // Disabled capture ignores frames.
    step(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 32'hBAD0_0000 + i, 32'hBAD1_0000, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0);
    chk(wr_valid == 0, "R9 frames ignored while disabled", 32'(wr_valid), 0);
    chk(q_data.size() == 0, "R5 all words delivered", q_data.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule